// File: doc/BRIEF.md
# Edge-interrupt GPIO bank controller

This block is a memory-mapped bank of 32 general-purpose lines, arranged as four 8-bit ports. Software sets each line as an input or an output, drives output values through an output latch, and reads back the line state. Every line has an edge detector. Its 2-bit field selects falling, rising or both edges, or turns the line off. The same field therefore acts as both the interrupt type and the interrupt mask.

Edges that are detected set bits in a pending-status register, and software clears those bits by writing ones. A single registered interrupt output, intended for a parent interrupt controller, is the OR of every pending bit whose line is enabled. The pins pass through a two-flop synchroniser before any use. The register port is a simple strobe bus: a 3-bit word address (byte offset = 4 × address), four byte enables that select byte or halfword lanes, and 32-bit data. Read data is combinational while the read strobe is high.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the direction, output-latch, edge-field and status registers read 0, and `irq`, `pin_oe` and `pin_out` are 0.
- R2: The direction word sits at byte offset 0x08. A 1 bit makes that line an output. `pin_oe` equals the direction bits and `pin_out` equals the output latch, and neither changes unless its own register is written.
- R3: The data word sits at offset 0x0C. A read returns the latch bit for output lines and the synchronised pin for input lines. A write changes only the output latch.
- R4: Byte enable k writes only bits [8k+7:8k], the byte that belongs to port k (port A in byte 0, up to port D in byte 3). The other bytes keep their values.
- R5: Edge fields use 2 bits per line. Line n of a port sits at bits [2n+1:2n] of that port's halfword: port A in bits 15:0 and port B in bits 31:16 of offset 0x14, port C in bits 15:0 and port D in bits 31:16 of offset 0x18. Code 1 selects only falling edges, so a rising edge on that line sets no status.
- R6: Code 2 selects only rising edges, code 3 selects both edges, and code 0 sets no status on any edge.
- R7: When a pin changes just after clock edge 0, its status bit is still 0 after edge 2 and set after edge 3. This delay comes from two synchroniser flops and one status flop.
- R8: The status word sits at offset 0x10. Writing a 1 in an enabled byte clears that bit. A 0 bit, or a disabled byte, leaves the bit unchanged.
- R9: If a selected edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: `irq` is registered. It rises one cycle after an enabled status bit sets, and it falls one cycle after that line's field is set to 0, while the status bit is kept.
- R11: A line configured as an output still sets its status bit on a selected edge at its pin.
- R12: Offsets 0x00, 0x04 and 0x1C read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe; read data is valid while it is high |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_word_addr | input | 3 | Word address (byte offset divided by 4) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per line (direction) |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that the write strobe and the address are stable around the sampling edge, and that a pin change is an ordinary level transition, so the synchroniser produces a clean single-cycle edge. The bench changes pins and bus signals only on falling clock edges. It holds each pin level for at least four cycles before it changes that pin again, so every edge reaches the detector exactly once. The same-cycle set and clear case is aligned on purpose to the cycle in which the detector fires.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 4;
  localparam int LINES     = PORT_W * NUM_PORTS;
  localparam int FIELD_W   = 2;
  localparam int TYP_W     = LINES * FIELD_W;
  localparam int BUS_W     = 32;
  localparam int BE_W      = BUS_W / 8;
  localparam int WADDR_W   = 3;

  localparam logic [WADDR_W-1:0] W_DIR    = 3'd2;
  localparam logic [WADDR_W-1:0] W_DATA   = 3'd3;
  localparam logic [WADDR_W-1:0] W_STATUS = 3'd4;
  localparam logic [WADDR_W-1:0] W_TYP_LO = 3'd5;
  localparam logic [WADDR_W-1:0] W_TYP_HI = 3'd6;

  typedef enum logic [FIELD_W-1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  // Expand byte enables into a bit mask.
  function automatic logic [BUS_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [BUS_W-1:0] m;
    for (int b = 0; b < BE_W; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // Replace only the enabled lanes of a word.
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [BE_W-1:0]  be);
    logic [BUS_W-1:0] m;
    m = lane_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Bit 1 of the field selects rising edges, bit 0 selects falling edges.
  function automatic logic edge_match(input logic [FIELD_W-1:0] sel,
                                      input logic prev, input logic cur);
    return (sel[1] & cur & ~prev) | (sel[0] & prev & ~cur);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_async;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         level,
  input  logic [WIDTH*FIELD_W-1:0] sel,
  output logic [WIDTH-1:0]         hit
);
  logic [WIDTH-1:0] level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= '0;
    else level_d <= level;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    assign hit[i] = edge_match(sel[i*FIELD_W +: FIELD_W], level_d[i], level[i]);
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_evt,
  input  logic [WIDTH-1:0] clr_req,
  input  logic [WIDTH-1:0] line_en,
  output logic [WIDTH-1:0] sts_q,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_req) | set_evt;
      irq   <= |(sts_q & line_en);
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WADDR_W-1:0] bus_word_addr,
  input  logic [BE_W-1:0]    bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [LINES-1:0]   pin_in,
  output logic [LINES-1:0]   pin_out,
  output logic [LINES-1:0]   pin_oe,
  output logic               irq
);
  logic [LINES-1:0] dir_q, out_q, pin_s, edge_hit, set_evt, line_en, sts_q, sts_clr;
  logic [TYP_W-1:0] typ_q;
  logic dir_wr, data_wr, status_wr, typ_lo_wr, typ_hi_wr;

  assign dir_wr    = bus_wr && (bus_word_addr == W_DIR);
  assign data_wr   = bus_wr && (bus_word_addr == W_DATA);
  assign status_wr = bus_wr && (bus_word_addr == W_STATUS);
  assign typ_lo_wr = bus_wr && (bus_word_addr == W_TYP_LO);
  assign typ_hi_wr = bus_wr && (bus_word_addr == W_TYP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      typ_q <= '0;
    end else begin
      if (dir_wr)    dir_q <= lane_merge(dir_q, bus_wdata, bus_be);
      if (data_wr)   out_q <= lane_merge(out_q, bus_wdata, bus_be);
      if (typ_lo_wr) typ_q[BUS_W-1:0] <= lane_merge(typ_q[BUS_W-1:0], bus_wdata, bus_be);
      if (typ_hi_wr) typ_q[TYP_W-1:BUS_W] <= lane_merge(typ_q[TYP_W-1:BUS_W], bus_wdata, bus_be);
    end
  end

  assign sts_clr = status_wr ? (bus_wdata & lane_mask(bus_be)) : '0;

  for (genvar i = 0; i < LINES; i++) begin : g_en
    assign line_en[i] = |typ_q[i*FIELD_W +: FIELD_W];
  end

  gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_s)
  );

  gpio_edge_det #(.WIDTH(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(pin_s), .sel(typ_q), .hit(edge_hit)
  );

  assign set_evt = edge_hit & line_en;

  gpio_irq_status #(.WIDTH(LINES)) u_status (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_req(sts_clr),
    .line_en(line_en), .sts_q(sts_q), .irq(irq)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_word_addr)
        W_DIR:    bus_rdata = dir_q;
        W_DATA:   bus_rdata = (dir_q & out_q) | (~dir_q & pin_s);
        W_STATUS: bus_rdata = sts_q;
        W_TYP_LO: bus_rdata = typ_q[BUS_W-1:0];
        W_TYP_HI: bus_rdata = typ_q[TYP_W-1:BUS_W];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dir_wr,
  input logic             data_wr,
  input logic             status_wr,
  input logic [LINES-1:0] pin_oe,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] sts_q,
  input logic [LINES-1:0] line_en,
  input logic [LINES-1:0] set_evt,
  input logic             irq
);
  assert_oe_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));

  assert_latch_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(pin_out));

  assert_no_set_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(line_en)) == '0));

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |=> (($past(sts_q) & ~sts_q) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && (set_evt != '0)) |=> ((sts_q & $past(set_evt)) == $past(set_evt)));

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & line_en) != '0) |=> irq);

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & line_en) == '0) |=> !irq);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .data_wr(data_wr),
  .status_wr(status_wr), .pin_oe(pin_oe), .pin_out(pin_out),
  .sts_q(sts_q), .line_en(line_en), .set_evt(set_evt), .irq(irq)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_word_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_SEL = 3'd0, A_GAP = 3'd1, A_DIR = 3'd2, A_DATA = 3'd3,
                         A_STS = 3'd4, A_TLO = 3'd5, A_THI = 3'd6, A_NXT = 3'd7;

  always #10 clk = ~clk;

  gpio_edge_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word_addr(bus_word_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_word_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    bus_word_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    peek(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 dir", A_DIR, 32'h0);
    expect_reg("R1 status", A_STS, 32'h0);
    expect_reg("R1 typ lo", A_TLO, 32'h0);
    expect_reg("R1 typ hi", A_THI, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
  endtask

  task automatic t_dir_data;
    wr(A_DIR, 32'h0000_00FF, 4'hF);
    check("R2 pin_oe", pin_oe, 32'h0000_00FF);
    wr(A_DATA, 32'hA5A5_A5A5, 4'hF);
    check("R2 pin_out", pin_out, 32'hA5A5_A5A5);
    check("R2 pin_oe unchanged by data write", pin_oe, 32'h0000_00FF);
    pin_in = 32'h1234_5678;
    wait_neg(3);
    expect_reg("R3 data mix", A_DATA, 32'h1234_56A5);
    check("R3 latch kept", pin_out, 32'hA5A5_A5A5);
  endtask

  task automatic t_byte_en;
    wr(A_DIR, 32'hFFFF_FFFF, 4'b0100);
    check("R4 dir lane 2 only", pin_oe, 32'h00FF_00FF);
    wr(A_DATA, 32'h0000_0000, 4'b0010);
    check("R4 data lane 1 only", pin_out, 32'hA5A5_00A5);
  endtask

  task automatic t_unmapped;
    wr(A_SEL, 32'hFFFF_FFFF, 4'hF);
    wr(A_GAP, 32'hFFFF_FFFF, 4'hF);
    wr(A_NXT, 32'hFFFF_FFFF, 4'hF);
    expect_reg("R12 offset 0x00", A_SEL, 32'h0);
    expect_reg("R12 offset 0x04", A_GAP, 32'h0);
    expect_reg("R12 offset 0x1C", A_NXT, 32'h0);
    check("R12 dir untouched", pin_oe, 32'h00FF_00FF);
    check("R12 latch untouched", pin_out, 32'hA5A5_00A5);
    expect_reg("R12 typ untouched", A_THI, 32'h0);
    wr(A_DIR, 32'h0, 4'hF);
    wr(A_DATA, 32'h0, 4'hF);
    pin_in = 32'h0;
    wait_neg(4);
    expect_reg("R6 code 0 sets nothing", A_STS, 32'h0);
  endtask

  task automatic t_falling;
    wr(A_TLO, 32'h0000_0040, 4'hF);
    pin_in[3] = 1'b1;
    wait_neg(4);
    expect_reg("R5 rising ignored on falling line", A_STS, 32'h0);
    pin_in[3] = 1'b0;
    wait_neg(2);
    expect_reg("R7 not yet after 2 edges", A_STS, 32'h0);
    wait_neg(1);
    expect_reg("R7 set after 3 edges", A_STS, 32'h0000_0008);
    check("R10 irq registered, still low", {31'h0, irq}, 32'h0);
    wait_neg(1);
    check("R10 irq high next cycle", {31'h0, irq}, 32'h1);
    wr(A_STS, 32'h0000_0008, 4'b0001);
    expect_reg("R8 cleared", A_STS, 32'h0);
    wait_neg(1);
    check("R10 irq low after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rise_both;
    wr(A_TLO, 32'h0038_0040, 4'hF);
    pin_in[11:9] = 3'b111;
    wait_neg(4);
    expect_reg("R6 rising+both, code0 off", A_STS, 32'h0000_0600);
    wr(A_STS, 32'h0000_0600, 4'b0010);
    pin_in[11:9] = 3'b000;
    wait_neg(4);
    expect_reg("R6 falling only on both line", A_STS, 32'h0000_0400);
  endtask

  task automatic t_w1c;
    wr(A_STS, 32'hFFFF_FFFF, 4'b0000);
    expect_reg("R8 no lanes enabled", A_STS, 32'h0000_0400);
    wr(A_STS, 32'h0000_0000, 4'hF);
    expect_reg("R8 zero write", A_STS, 32'h0000_0400);
    wr(A_STS, 32'h0000_0400, 4'hF);
    expect_reg("R8 one clears", A_STS, 32'h0);
  endtask

  task automatic t_set_wins;
    pin_in[10] = 1'b1;
    wait_neg(4);
    expect_reg("R9 precondition", A_STS, 32'h0000_0400);
    pin_in[10] = 1'b0;
    wait_neg(2);
    bus_wr = 1'b1; bus_word_addr = A_STS; bus_wdata = 32'h0000_0400; bus_be = 4'hF;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    expect_reg("R9 set beats clear", A_STS, 32'h0000_0400);
    wait_neg(2);
    wr(A_STS, 32'h0000_0400, 4'hF);
    expect_reg("R8 clear after", A_STS, 32'h0);
  endtask

  task automatic t_irq_mask;
    pin_in[3] = 1'b1;
    wait_neg(4);
    pin_in[3] = 1'b0;
    wait_neg(4);
    check("R10 irq up", {31'h0, irq}, 32'h1);
    wr(A_TLO, 32'h0038_0000, 4'hF);
    wait_neg(1);
    check("R10 irq drops when field off", {31'h0, irq}, 32'h0);
    expect_reg("R10 status kept", A_STS, 32'h0000_0008);
    wr(A_STS, 32'h0000_0008, 4'hF);
  endtask

  task automatic t_output_edge;
    wr(A_THI, 32'h4000_0008, 4'hF);
    wr(A_DIR, 32'h0002_0000, 4'hF);
    pin_in[17] = 1'b1;
    wait_neg(4);
    expect_reg("R11 output line edge", A_STS, 32'h0002_0000);
    expect_reg("R3 output line reads latch", A_DATA, 32'h0);
    wr(A_STS, 32'h0002_0000, 4'b0100);
    wr(A_DIR, 32'h0, 4'hF);
  endtask

  task automatic t_port_d;
    pin_in[31] = 1'b1;
    wait_neg(4);
    expect_reg("R5 port D rising ignored", A_STS, 32'h0);
    pin_in[31] = 1'b0;
    wait_neg(4);
    expect_reg("R5 port D line 7 falling", A_STS, 32'h8000_0000);
    check("R10 irq port D", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_data();
    t_byte_en();
    t_unmapped();
    t_falling();
    t_rise_both();
    t_w1c();
    t_set_wins();
    t_irq_mask();
    t_output_edge();
    t_port_d();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule